// File: doc/BRIEF.md
# Phase Recalibration Sequencer

This block orders the steps that bring a DPLL's feedback synthesizer back into line with the output dividers. Phase build-out events can leave the two misaligned. Software starts a run by setting a recalibrate bit, modelled here as a one-cycle `recal_set` write strobe. The bit reads back as `busy` and clears by itself when the run finishes.

During a run the sequencer does five things in order:

1. It holds the loop in forced mini-holdover.
2. It walks the applied phase offset down to zero.
3. It pulses a global divider reset while the offset sits at zero.
4. It walks the offset back up to the programmed value.
5. It releases holdover.

The programmed value is `ofs_target`. It is sampled on every clock during the up-walk, so a write made mid-run is honoured. When no run is in progress, the programmed value passes to `ofs_applied` with one register of delay.

The offset is a two's-complement number in units of the fine phase step (nominally 6 ps). The ramps move by `step_size` units on each prescaler tick. A tick falls once every `presc_div + 1` clocks.

All pins are plain control and status levels; the block carries no data stream, so no valid/ready handshake and no back-pressure rules apply.

Top module: `phase_recal_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, `busy`, `force_mhold`, `div_rst` and `done` are 0 and `ofs_applied` is 0.
- R2: While idle, `ofs_applied` equals the value `ofs_target` had one clock earlier.
- R3: A `recal_set` strobe seen while idle raises `busy` and `force_mhold` on the next clock. Strobes seen while `busy` is high have no effect on the run or on any later cycle.
- R4: After one holdover-entry cycle, `ofs_applied` moves toward zero. The prescaler counter starts at 0 on entry, and a tick fires on the clock where it equals `presc_div`. On each tick the offset moves by `step_size`, and the last move lands exactly on zero with no overshoot.
- R5: On the clock after the down-walk finds the offset at zero, `div_rst` goes high. It stays high for exactly RST_LEN (4) consecutive clocks, and `ofs_applied` is 0 throughout.
- R6: The up-walk starts only after `div_rst` falls. It moves toward the current `ofs_target` by at most `step_size` per tick and stops exactly on it. A target change during the run redirects it.
- R7: When the up-walk finds `ofs_applied` equal to `ofs_target`, `busy` and `force_mhold` fall on the next clock, and `done` is high for that one clock only.
- R8: Offsets are signed two's complement. Negative targets walk down to zero and back below zero symmetrically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recal_set | input | 1 | Software write strobe that sets the recalibrate bit |
| ofs_target | input | OFS_W | Programmed phase offset, signed |
| step_size | input | STEP_W | Ramp increment per tick, unsigned, nonzero |
| presc_div | input | PRESC_W | Prescaler: one tick every presc_div+1 clocks |
| ofs_applied | output | OFS_W | Phase offset handed to the feedback path, signed |
| force_mhold | output | 1 | Request to hold the DPLL in mini-holdover |
| div_rst | output | 1 | Global output-divider reset |
| busy | output | 1 | Recalibrate bit read-back, high during a run |
| done | output | 1 | One-clock pulse when holdover is released |

## Verification
The bench uses the default widths: a 16-bit offset, an 8-bit step, an 8-bit prescaler and a 4-clock reset pulse. Within those widths it varies `presc_div` between 0 and 2, and `step_size` across 1, 3, 4 and 255. These values cover single-unit walks, a final partial step clamped to the target, and one step that crosses the whole range. It also covers runs that begin with the offset already at zero, negative targets, and target writes made during both walks.

// File: rtl/recal_pkg.sv
package recal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_DOWN = 3'd2,
    ST_DRST = 3'd3,
    ST_UP   = 3'd4
  } recal_st_e;
endpackage

// File: rtl/recal_tick_gen.sv
module recal_tick_gen #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [PRESC_W-1:0] div,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick = !clear && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R4: the counter never runs past the programmed divide value while counting
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && $past(rst_n) && $past(!clear) && $stable(div)) |-> (cnt_q <= div));
endmodule

// File: rtl/recal_ramp_step.sv
module recal_ramp_step #(
  parameter int W  = 16,
  parameter int SW = 8
) (
  input  logic signed [W-1:0] cur,
  input  logic signed [W-1:0] tgt,
  input  logic        [SW-1:0] step,
  output logic signed [W-1:0] nxt,
  output logic                at_tgt
);
  localparam int DW = W + 1;

  logic signed [DW-1:0] diff;
  logic signed [DW-1:0] stp;
  logic signed [DW-1:0] neg_stp;

  assign diff    = {tgt[W-1], tgt} - {cur[W-1], cur};
  assign stp     = {{(DW-SW){1'b0}}, step};
  assign neg_stp = -stp;
  assign at_tgt  = (diff == '0);

  always_comb begin
    if (diff > stp)          nxt = cur + stp[W-1:0];
    else if (diff < neg_stp) nxt = cur - stp[W-1:0];
    else                     nxt = tgt;
  end

  initial begin
    assert (DW > SW) else $error("step wider than offset");
  end
endmodule

// File: rtl/recal_pulse_gen.sv
module recal_pulse_gen #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q;

  assign last = run && (cnt_q == CW'(LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (!last) cnt_q <= cnt_q + 1'b1;
  end

  // R5: the reset window only ends after its full length
  p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(run)) |-> $past(cnt_q == CW'(LEN - 1)));
endmodule

// File: rtl/phase_recal_seq.sv
module phase_recal_seq
  import recal_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int STEP_W  = 8,
  parameter int PRESC_W = 8,
  parameter int RST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    recal_set,
  input  logic signed [OFS_W-1:0] ofs_target,
  input  logic [STEP_W-1:0]       step_size,
  input  logic [PRESC_W-1:0]      presc_div,
  output logic signed [OFS_W-1:0] ofs_applied,
  output logic                    force_mhold,
  output logic                    div_rst,
  output logic                    busy,
  output logic                    done
);
  recal_st_e state_q, state_d;
  logic signed [OFS_W-1:0] app_q, app_d;
  logic signed [OFS_W-1:0] ramp_tgt, ramp_nxt;
  logic ramp_at, tick, tick_clr, rst_last, done_q;

  assign ramp_tgt = (state_q == ST_UP) ? ofs_target : '0;
  assign tick_clr = (state_q != ST_DOWN) && (state_q != ST_UP);

  recal_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear(tick_clr), .div(presc_div), .tick(tick)
  );

  recal_ramp_step #(.W(OFS_W), .SW(STEP_W)) u_step (
    .cur(app_q), .tgt(ramp_tgt), .step(step_size), .nxt(ramp_nxt), .at_tgt(ramp_at)
  );

  recal_pulse_gen #(.LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_DRST), .last(rst_last)
  );

  always_comb begin
    state_d = state_q;
    app_d   = app_q;
    case (state_q)
      ST_IDLE: begin
        app_d = ofs_target;
        if (recal_set) state_d = ST_HOLD;
      end
      ST_HOLD: state_d = ST_DOWN;
      ST_DOWN: begin
        if (ramp_at) state_d = ST_DRST;
        else if (tick) app_d = ramp_nxt;
      end
      ST_DRST: if (rst_last) state_d = ST_UP;
      ST_UP: begin
        if (ramp_at) state_d = ST_IDLE;
        else if (tick) app_d = ramp_nxt;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      app_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      app_q   <= app_d;
      done_q  <= (state_q == ST_UP) && ramp_at;
    end
  end

  assign ofs_applied = app_q;
  assign busy        = (state_q != ST_IDLE);
  assign force_mhold = busy;
  assign div_rst     = (state_q == ST_DRST);
  assign done        = done_q;

  function automatic int unsigned mag(input logic signed [OFS_W-1:0] a,
                                      input logic signed [OFS_W-1:0] b);
    int d;
    d = int'(a) - int'(b);
    return (d < 0) ? int'(-d) : int'(d);
  endfunction

  // R1: outputs quiet on the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    (rst_n && $past(!rst_n)) |-> (!busy && !div_rst && !done && ofs_applied == '0));

  // R2: idle pass-through of the programmed offset
  p_idle_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !busy && $past(!busy)) |-> (ofs_applied == $past(ofs_target)));

  // R3: a run only begins after a strobe
  p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(busy)) |-> $past(recal_set));

  // R4 / R6: each move during a run is at most one step
  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && busy && $past(busy))
      |-> (mag(ofs_applied, $past(ofs_applied)) <= int'($past(step_size))));

  // R5: dividers reset only with the offset at zero
  p_rst_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |-> (ofs_applied == '0));

  // R7: completion pulse accompanies the release
  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(ofs_applied == ofs_target)));
endmodule

// File: tb/tb_phase_recal_seq.sv
module tb_phase_recal_seq;
  localparam int OFS_W = 16, STEP_W = 8, PRESC_W = 8, RST_LEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recal_set = 1'b0;
  logic signed [OFS_W-1:0] ofs_target = '0;
  logic [STEP_W-1:0] step_size = 8'd1;
  logic [PRESC_W-1:0] presc_div = '0;
  logic signed [OFS_W-1:0] ofs_applied;
  logic force_mhold, div_rst, busy, done;

  always #4 clk = ~clk;

  phase_recal_seq #(.OFS_W(OFS_W), .STEP_W(STEP_W), .PRESC_W(PRESC_W), .RST_LEN(RST_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .recal_set(recal_set), .ofs_target(ofs_target),
    .step_size(step_size), .presc_div(presc_div), .ofs_applied(ofs_applied),
    .force_mhold(force_mhold), .div_rst(div_rst), .busy(busy), .done(done)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  int m_st = 0, m_app = 0, m_cnt = 0, m_r = 0;
  bit m_done = 0;
  int rst_cycles = 0, done_count = 0;

  function automatic int toward(int c, int t, int s);
    if (t - c > s) return c + s;
    if (c - t > s) return c - s;
    return t;
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int tgt;
    tgt = int'(ofs_target);
    if (!rst_n) begin
      m_st = 0; m_app = 0; m_cnt = 0; m_r = 0; m_done = 0;
    end else begin
      m_done = (m_st == 4) && (m_app == tgt);
      case (m_st)
        0: begin m_app = tgt; if (recal_set) m_st = 1; end
        1: begin m_st = 2; m_cnt = 0; end
        2: begin
          if (m_app == 0) begin m_st = 3; m_r = 0; end
          else if (m_cnt == int'(presc_div)) begin m_cnt = 0; m_app = toward(m_app, 0, int'(step_size)); end
          else m_cnt++;
        end
        3: begin
          if (m_r == RST_LEN - 1) begin m_st = 4; m_cnt = 0; end
          else m_r++;
        end
        default: begin
          if (m_app == tgt) m_st = 0;
          else if (m_cnt == int'(presc_div)) begin m_cnt = 0; m_app = toward(m_app, tgt, int'(step_size)); end
          else m_cnt++;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy == (m_st != 0), "R3 busy", busy, m_st != 0);
      chk(force_mhold == (m_st != 0), "R7 force_mhold", force_mhold, m_st != 0);
      chk(int'(ofs_applied) == m_app, "R4 ofs_applied", int'(ofs_applied), m_app);
      chk(div_rst == (m_st == 3), "R5 div_rst", div_rst, m_st == 3);
      chk(done == m_done, "R7 done", done, m_done);
      if (div_rst) rst_cycles++;
      if (done) done_count++;
    end
  end

  task automatic trigger();
    @(negedge clk); recal_set = 1'b1;
    @(negedge clk); recal_set = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    #1;
  endtask

  task automatic run_check(input int exp_final, input string req);
    rst_cycles = 0; done_count = 0;
    trigger();
    wait_done();
    chk(rst_cycles == RST_LEN, "R5 pulse length", rst_cycles, RST_LEN);
    chk(int'(ofs_applied) == exp_final, req, int'(ofs_applied), exp_final);
    @(negedge clk);
    chk(done_count == 1, "R7 single done", done_count, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !div_rst && !done && ofs_applied == 0, "R1 reset state", int'(ofs_applied), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && ofs_applied == 0, "R1 after reset", int'(ofs_applied), 0);

    // R2: idle pass-through
    ofs_target = 16'sd100; @(negedge clk);
    chk(ofs_applied == 16'sd100, "R2 idle track", int'(ofs_applied), 100);
    ofs_target = -16'sd50; @(negedge clk);
    chk(ofs_applied == -16'sd50, "R2 idle track neg", int'(ofs_applied), -50);

    // R4: unit-free walk with clamped final step, prescaler off
    ofs_target = 16'sd20; step_size = 8'd3; presc_div = 8'd0;
    repeat (2) @(negedge clk);
    run_check(20, "R4 run ends on target");

    // R8 and R6: negative target, prescaled, target rewritten during down-walk
    ofs_target = -16'sd17; step_size = 8'd4; presc_div = 8'd2;
    repeat (2) @(negedge clk);
    trigger();
    repeat (6) @(negedge clk);
    chk(busy && ofs_applied < 0, "R8 negative walking to zero", int'(ofs_applied), -1);
    ofs_target = 16'sd9;
    wait_done();
    chk(ofs_applied == 16'sd9, "R6 follows mid-run write", int'(ofs_applied), 9);

    // R6: target rewritten during up-walk, plus R3 triggers while busy
    ofs_target = 16'sd30; step_size = 8'd1; presc_div = 8'd0;
    repeat (2) @(negedge clk);
    trigger();
    while (!div_rst) @(negedge clk);
    while (div_rst) @(negedge clk);
    recal_set = 1'b1; @(negedge clk); recal_set = 1'b0;
    repeat (3) @(negedge clk);
    ofs_target = -16'sd12;
    wait_done();
    chk(ofs_applied == -16'sd12, "R6 up-walk redirected", int'(ofs_applied), -12);
    repeat (5) @(negedge clk);
    chk(!busy, "R3 strobe during run ignored", busy, 0);

    // R5: run starting at zero goes straight to divider reset
    ofs_target = 16'sd0; repeat (2) @(negedge clk);
    run_check(0, "R5 zero start");

    // R4: one large step crosses the full distance
    ofs_target = 16'sd200; step_size = 8'd255; presc_div = 8'd1;
    repeat (2) @(negedge clk);
    run_check(200, "R4 large step no overshoot");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule